// File: doc/BRIEF.md
# Two-Bit Burst Address Generator

This block turns one starting word address into the four addresses of a burst. A load strobe captures the whole start address. Each clock edge that sees the active-low advance input low then steps the burst by one beat. After the fourth beat the sequence comes back to the captured start address. Only the two lowest address bits are sequenced. The upper bits pass through from the captured address and never change during a burst.

The beat order is chosen at run time by a mode input. When the mode is high the order is interleaved: the low field is the start field XOR the beat number. When the mode is low the order is linear: the low field counts upward modulo four from the start field. The mode acts on the output combinationally. Changing it mid-burst changes the order that is presented, but it does not touch the beat count.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset `addr_o` is all zeros and the beat count is zero.
- R2: In the cycle after a clock edge with `load_i` high, `addr_o` equals the `start_addr_i` sampled at that edge, in either mode, because beat zero always presents the start field.
- R3: When `load_i` and advance are both active on one edge, the load wins: the beat count restarts at zero and does not step.
- R4: Each rising edge with `adv_n_i` low and `load_i` low steps the beat count by exactly one, modulo four.
- R5: An edge with `adv_n_i` high and `load_i` low leaves the beat count and the captured address unchanged.
- R6: With `interleave_i` high, `addr_o[1:0]` is the start field XOR the beat number. Start 00 gives 00,01,10,11. Start 01 gives 01,00,11,10. Start 10 gives 10,11,00,01. Start 11 gives 11,10,01,00.
- R7: With `interleave_i` low, `addr_o[1:0]` is the start field plus the beat number modulo 4. For example, start 10 gives 10,11,00,01.
- R8: An advance from the fourth beat wraps the beat count to zero, so `addr_o` returns to the loaded start address.
- R9: Bits `addr_o[ADDR_W-1:2]` equal the loaded start address bits and change only on a load.
- R10: Toggling `interleave_i` while holding changes `addr_o[1:0]` at once to the other order for the same beat, and leaves the beat count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Captures the start address and restarts the burst |
| start_addr_i | input | ADDR_W | Start word address |
| adv_n_i | input | 1 | Active-low advance; steps one beat per edge |
| interleave_i | input | 1 | 1 = interleaved order, 0 = linear order |
| addr_o | output | ADDR_W | Current burst address |

## Verification
The bench builds the block with `ADDR_W` set to 8. With that width, random start addresses cover the whole upper field often, so a corrupted upper bit shows up quickly, while every low-field start value and every beat occurs many times in both orders. Random streams of load, advance and mode bits also produce the collisions of load with advance, long holds and mode flips mid-burst. Directed runs add full four-beat wraps from every start value in both modes.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int unsigned BEAT_W = 2;
  localparam int unsigned BEATS  = 1 << BEAT_W;

  typedef logic [BEAT_W-1:0] beat_t;

  typedef enum logic {
    ORDER_LINEAR     = 1'b0,
    ORDER_INTERLEAVE = 1'b1
  } order_e;

  // interleaved: start field XOR beat index
  function automatic beat_t order_xor(input beat_t start, input beat_t beat);
    return start ^ beat;
  endfunction

  // linear: start field plus beat index, wraps modulo BEATS
  function automatic beat_t order_add(input beat_t start, input beat_t beat);
    return beat_t'(start + beat);
  endfunction

  function automatic beat_t order_pick(input order_e mode, input beat_t start,
                                       input beat_t beat);
    return (mode == ORDER_INTERLEAVE) ? order_xor(start, beat)
                                      : order_add(start, beat);
  endfunction
endpackage

// File: rtl/burst_beat_counter.sv
module burst_beat_counter
  import burst_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  restart,
  input  logic  step,
  output beat_t beat_q,
  output logic  wrap
);
  localparam beat_t LAST_BEAT = beat_t'(BEATS - 1);

  assign wrap = step && !restart && (beat_q == LAST_BEAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       beat_q <= '0;
    else if (restart) beat_q <= '0;
    else if (step)    beat_q <= beat_t'(beat_q + beat_t'(1));
  end
endmodule

// File: rtl/burst_base_reg.sv
module burst_base_reg #(
  parameter int unsigned ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [ADDR_W-1:0] addr_d,
  output logic [ADDR_W-1:0] addr_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (capture) addr_q <= addr_d;
  end
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_pkg::*;
#(
  parameter int unsigned ADDR_W = 19
) (
  input  logic [ADDR_W-1:0] base,
  input  beat_t             beat,
  input  order_e            mode,
  output logic [ADDR_W-1:0] addr
);
  localparam int unsigned HI_W = ADDR_W - BEAT_W;

  generate
    if (HI_W > 0) begin : g_hi
      assign addr[ADDR_W-1:BEAT_W] = base[ADDR_W-1:BEAT_W];
    end
  endgenerate

  assign addr[BEAT_W-1:0] = order_pick(mode, base[BEAT_W-1:0], beat);
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int unsigned ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              adv_n_i,
  input  logic              interleave_i,
  output logic [ADDR_W-1:0] addr_o
);
  // named internal events for the checker
  logic              load_evt;
  logic              step_evt;
  logic              wrap_evt;
  beat_t             beat_cnt;
  logic [ADDR_W-1:0] base_addr;
  order_e            order_sel;

  assign load_evt  = load_i;
  assign step_evt  = !adv_n_i && !load_i;
  assign order_sel = interleave_i ? ORDER_INTERLEAVE : ORDER_LINEAR;

  burst_base_reg #(.ADDR_W(ADDR_W)) u_base (
    .clk    (clk),
    .rst_n  (rst_n),
    .capture(load_evt),
    .addr_d (start_addr_i),
    .addr_q (base_addr)
  );

  burst_beat_counter u_beat (
    .clk    (clk),
    .rst_n  (rst_n),
    .restart(load_evt),
    .step   (step_evt),
    .beat_q (beat_cnt),
    .wrap   (wrap_evt)
  );

  burst_order_map #(.ADDR_W(ADDR_W)) u_map (
    .base(base_addr),
    .beat(beat_cnt),
    .mode(order_sel),
    .addr(addr_o)
  );
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int unsigned ADDR_W = 19
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load_i,
  input logic              adv_n_i,
  input logic [ADDR_W-1:0] start_addr_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic [1:0]        beat_cnt,
  input logic [ADDR_W-1:0] base_addr,
  input logic              wrap_evt
);
  AST_LOAD_PRESENTS_START: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> addr_o == $past(start_addr_i)); // R2
  AST_LOAD_BEATS_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !adv_n_i) |=> beat_cnt == 2'd0); // R3
  AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !adv_n_i) |=> beat_cnt == 2'($past(beat_cnt) + 2'd1)); // R4
  AST_HOLD_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && adv_n_i) |=> ($stable(beat_cnt) && $stable(base_addr))); // R5
  AST_WRAP_HOME: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> addr_o[1:0] == base_addr[1:0]); // R8
  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(addr_o[ADDR_W-1:2])); // R9
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .load_i      (load_i),
  .adv_n_i     (adv_n_i),
  .start_addr_i(start_addr_i),
  .addr_o      (addr_o),
  .beat_cnt    (beat_cnt),
  .base_addr   (base_addr),
  .wrap_evt    (wrap_evt)
);

// File: tb/burst_addr_gen_test.sv
module burst_addr_gen_test;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          load_i = 1'b0;
  logic [AW-1:0] start_addr_i = '0;
  logic          adv_n_i = 1'b1;
  logic          interleave_i = 1'b0;
  logic [AW-1:0] addr_o;

  int n_chk = 0;
  int n_bad = 0;
  int m_base = 0;
  int m_beat = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .start_addr_i(start_addr_i),
    .adv_n_i(adv_n_i), .interleave_i(interleave_i), .addr_o(addr_o));

  // expected low field, computed bit by bit / arithmetically
  function automatic int exp_low(input int s, input int b, input bit il);
    if (il) return (((s / 2) % 2) != ((b / 2) % 2) ? 2 : 0) + ((s % 2) != (b % 2) ? 1 : 0);
    return (s + b) % 4;
  endfunction

  function automatic int exp_addr(input bit il);
    return (m_base / 4) * 4 + exp_low(m_base % 4, m_beat, il);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one clock: apply inputs, update model at edge, check at negedge
  task automatic step(input bit ld, input int sa, input bit advn, input bit il);
    string tag;
    load_i = ld; start_addr_i = AW'(sa); adv_n_i = advn; interleave_i = il;
    @(posedge clk);
    if (ld) begin m_base = sa; m_beat = 0; end
    else if (!advn) m_beat = (m_beat + 1) % 4;
    @(negedge clk);
    if (ld) tag = advn ? "R2" : "R3";
    else if (advn) tag = "R5";
    else tag = il ? "R4 R6" : "R4 R7";
    chk(tag, int'(addr_o), exp_addr(il));
    chk("R9", int'(addr_o) / 4, m_base / 4);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    #12;
    chk("R1", int'(addr_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // directed: full bursts from each start in both modes, wrap checked
    for (int md = 0; md < 2; md++) begin
      for (int s = 0; s < 4; s++) begin
        step(1'b1, 8'hA4 + s, 1'b1, md[0]);
        for (int b = 0; b < 4; b++) step(1'b0, 0, 1'b0, md[0]);
        chk("R8", int'(addr_o), 8'hA4 + s);
      end
    end
    // directed: mode flip while holding at beat 1 of start 10
    step(1'b1, 8'h36, 1'b1, 1'b1);
    step(1'b0, 0, 1'b0, 1'b1);
    chk("R6", int'(addr_o[1:0]), 2'b11);
    interleave_i = 1'b0;
    #1;
    chk("R10", int'(addr_o[1:0]), 2'b11);
    step(1'b0, 0, 1'b0, 1'b0);
    chk("R10", int'(addr_o[1:0]), 2'b00);
    interleave_i = 1'b1;
    #1;
    chk("R10", int'(addr_o[1:0]), 2'b00);
    step(1'b0, 0, 1'b1, 1'b1);
    chk("R10", int'(addr_o[1:0]), 2'b00);
    // directed: load colliding with advance
    step(1'b1, 8'h5B, 1'b0, 1'b0);
    chk("R3", int'(addr_o), 8'h5B);
    // random mix
    for (int i = 0; i < 600; i++) begin
      step(($urandom % 6) == 0, int'($urandom % 256), ($urandom % 3) == 0,
           ($urandom % 8) != 0 ? interleave_i : ~interleave_i);
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule